// File: doc/BRIEF.md
# Receive Descriptor Writeback Formatter

This block turns the outcome of one received frame into the 128-bit record that a receive engine writes back over a descriptor slot. A 3-bit format selector picks one of two layouts: a compact legacy record that keeps the buffer address in its low half, or an extended single-buffer record. The extended record carries wider status and error fields, a packet-class field, and a 32-bit slot that holds either the IP identification and the checksum or an RSS hash, which is written as zero here. Both error encodings, 8-bit and 12-bit, are derived side by side from the same checksum verdicts.

The caller presents the frame length, the CRC-strip setting, the protocol flags (IPv4, TCP, UDP), the two checksum verdicts, the 16-bit IP identification, the raw checksum, the buffer address and the 16-bit checksum-control word with a one-cycle strobe. One cycle later the block either pulses a valid flag with the finished record, or pulses an error flag when the selector names a layout it does not support. The block does not compute checksums. VLAN tag, RSS type, RSS hash, header length and split-header indication are always written as zero.

Top module: `rx_wb_formatter`

## Requirements
- R1: Selector value 0 picks the legacy layout and value 1 picks the extended layout. Values 2 to 7 pulse `wb_type_err` in the cycle after the strobe with `wb_valid` low, and leave `wb_word` unchanged.
- R2: A strobe with a supported selector gives a one-cycle `wb_valid` pulse in the next cycle. Without a strobe both flags stay low and `wb_word` holds its value. After reset the flags and the word are zero.
- R3: The reported length is `pkt_len + 4` (modulo 2^16) when `crc_strip_en` is 0, and `pkt_len` when it is 1. It sits in bits 79:64 (legacy) or 111:96 (extended).
- R4: Status always has bit 0 (descriptor done) and bit 1 (end of packet) set.
- R5: When `is_ipv4` is 1 and `csum_ctl` bit 8 is 1, status bit 6 is set. If `ip_csum_bad` is also 1, legacy error bit 6 and extended error bit 11 are set. Otherwise `ip_csum_bad` has no effect.
- R6: With `is_ipv4` and `csum_ctl` bit 9 both 1, `is_tcp` sets status bit 5 and `is_udp` sets status bit 4. If either of these is set and `l4_csum_bad` is 1, legacy error bit 5 and extended error bit 10 are set. Without both conditions, `is_tcp`, `is_udp` and `l4_csum_bad` have no effect.
- R7: The extended packet-class field (bits 15:4) has bit 0 for IPv4, bit 4 for a TCP checksum that was checked, and bit 5 for a UDP checksum that was checked.
- R8: In the extended layout, `csum_ctl` bit 13 = 1 makes bits 63:32 zero. Otherwise bits 47:32 hold the IP identification (zero for a non-IPv4 frame) and bits 63:48 hold the raw checksum (zero unless some checksum was checked). The extended status is in bits 83:64 and the errors in bits 95:84.
- R9: The legacy layout has the buffer address in bits 63:0, the checksum (same rule as R8) in bits 95:80, status in bits 103:96 and errors in bits 111:104.
- R10: VLAN (bits 127:112) is always zero. In the extended layout, bits 3:0 and 31:16 are zero. Every status and error bit not named in R4 to R6 is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe: frame result present |
| desc_type | input | 3 | Record format selector |
| crc_strip_en | input | 1 | CRC bytes already removed from the length |
| pkt_len | input | 16 | Frame length in bytes |
| is_ipv4 | input | 1 | Frame carries IPv4 |
| is_tcp | input | 1 | Frame carries TCP |
| is_udp | input | 1 | Frame carries UDP |
| ip_csum_bad | input | 1 | IP header checksum verdict: bad |
| l4_csum_bad | input | 1 | TCP/UDP checksum verdict: bad |
| csum_ctl | input | 16 | Checksum control: bit 8 IP check, bit 9 L4 check, bit 13 hash slot |
| ip_id | input | 16 | IP identification field |
| raw_csum | input | 16 | Raw checksum value |
| buf_addr | input | 64 | Buffer address for the legacy record |
| wb_valid | output | 1 | Record ready (one-cycle pulse) |
| wb_type_err | output | 1 | Unsupported selector (one-cycle pulse) |
| wb_word | output | 128 | Writeback record |

## Verification
The hardest case to reach is the one where a layout's rules interact. An error bit must appear only when its check is enabled and the frame is IPv4. The shared slot must switch between identification/checksum and zero. All of this must hold while an unsupported selector leaves the previous record untouched. The stimulus therefore sweeps every combination of selector, CRC-strip, the five protocol and enable flags, both verdicts and the slot mode. Unrelated bits of the control word are driven with noise. Each strobe is followed by an idle cycle, so that holding and single-cycle pulsing are checked after every vector.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

  localparam int WB_W      = 128;
  localparam int LEN_W     = 16;
  localparam int STAT_W    = 20;
  localparam int LEG_ERR_W = 8;
  localparam int EXT_ERR_W = 12;
  localparam int PTYPE_W   = 12;
  localparam int ADDR_W    = 64;

  // status bits shared by both layouts
  localparam logic [STAT_W-1:0] ST_DONE  = 20'h00001;
  localparam logic [STAT_W-1:0] ST_EOP   = 20'h00002;
  localparam logic [STAT_W-1:0] ST_UDPOK = 20'h00010;
  localparam logic [STAT_W-1:0] ST_TCPOK = 20'h00020;
  localparam logic [STAT_W-1:0] ST_IPOK  = 20'h00040;

  localparam logic [LEG_ERR_W-1:0] LE_IP = 8'h40;
  localparam logic [LEG_ERR_W-1:0] LE_L4 = 8'h20;
  localparam logic [EXT_ERR_W-1:0] XE_IP = 12'h800;
  localparam logic [EXT_ERR_W-1:0] XE_L4 = 12'h400;

  localparam logic [PTYPE_W-1:0] PC_IPV4 = 12'h001;
  localparam logic [PTYPE_W-1:0] PC_TCP  = 12'h010;
  localparam logic [PTYPE_W-1:0] PC_UDP  = 12'h020;

  typedef struct packed {
    logic [STAT_W-1:0]    status;
    logic [LEG_ERR_W-1:0] err_leg;
    logic [EXT_ERR_W-1:0] err_ext;
    logic [PTYPE_W-1:0]   pclass;
    logic [15:0]          csum;
    logic [15:0]          ident;
  } rx_result_t;

endpackage

// File: rtl/rxwb_classify.sv
module rxwb_classify
  import rxwb_pkg::*;
#(
  parameter int IP_EN_BIT = 8,
  parameter int L4_EN_BIT = 9
) (
  input  logic        is_ipv4,
  input  logic        is_tcp,
  input  logic        is_udp,
  input  logic        ip_csum_bad,
  input  logic        l4_csum_bad,
  input  logic [15:0] csum_ctl,
  input  logic [15:0] ip_id,
  input  logic [15:0] raw_csum,
  output rx_result_t  res
);

  logic ip_chk;
  logic tcp_chk;
  logic udp_chk;
  logic l4_chk;
  logic any_chk;

  always_comb begin
    ip_chk  = is_ipv4 & csum_ctl[IP_EN_BIT];
    tcp_chk = is_ipv4 & is_tcp & csum_ctl[L4_EN_BIT];
    udp_chk = is_ipv4 & is_udp & csum_ctl[L4_EN_BIT];
    l4_chk  = tcp_chk | udp_chk;
    any_chk = ip_chk | l4_chk;
  end

  always_comb begin
    res = '0;
    res.status = ST_DONE | ST_EOP;
    if (ip_chk)  res.status = res.status | ST_IPOK;
    if (tcp_chk) res.status = res.status | ST_TCPOK;
    if (udp_chk) res.status = res.status | ST_UDPOK;

    if (ip_chk && ip_csum_bad) begin
      res.err_leg = res.err_leg | LE_IP;
      res.err_ext = res.err_ext | XE_IP;
    end
    if (l4_chk && l4_csum_bad) begin
      res.err_leg = res.err_leg | LE_L4;
      res.err_ext = res.err_ext | XE_L4;
    end

    if (is_ipv4) res.pclass = res.pclass | PC_IPV4;
    if (tcp_chk) res.pclass = res.pclass | PC_TCP;
    if (udp_chk) res.pclass = res.pclass | PC_UDP;

    res.csum  = any_chk ? raw_csum : 16'h0000;
    res.ident = is_ipv4 ? ip_id : 16'h0000;
  end

endmodule

// File: rtl/rxwb_pack.sv
module rxwb_pack
  import rxwb_pkg::*;
#(
  parameter bit EXTENDED = 1'b0
) (
  input  rx_result_t        res,
  input  logic [LEN_W-1:0]  len_rep,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic              hash_slot,
  output logic [WB_W-1:0]   word
);

  localparam int HDR_LEN_W = 10;
  localparam int RSVD_W    = 5;
  localparam int RSS_T_W   = 4;
  localparam int VLAN_W    = 16;

  generate
    if (EXTENDED) begin : g_ext
      logic [31:0] slot;
      always_comb begin
        slot = hash_slot ? 32'h0 : {res.csum, res.ident};
        word = {{VLAN_W{1'b0}}, len_rep, res.err_ext, res.status, slot,
                1'b0, {HDR_LEN_W{1'b0}}, {RSVD_W{1'b0}}, res.pclass,
                {RSS_T_W{1'b0}}};
      end
    end else begin : g_leg
      always_comb begin
        word = {{VLAN_W{1'b0}}, res.err_leg, res.status[7:0], res.csum,
                len_rep, buf_addr};
      end
    end
  endgenerate

endmodule

// File: rtl/rx_wb_formatter.sv
module rx_wb_formatter
  import rxwb_pkg::*;
#(
  parameter int CRC_BYTES   = 4,
  parameter int IP_EN_BIT   = 8,
  parameter int L4_EN_BIT   = 9,
  parameter int HASH_SEL_BIT = 13,
  parameter int NUM_FMT     = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    desc_type,
  input  logic          crc_strip_en,
  input  logic [15:0]   pkt_len,
  input  logic          is_ipv4,
  input  logic          is_tcp,
  input  logic          is_udp,
  input  logic          ip_csum_bad,
  input  logic          l4_csum_bad,
  input  logic [15:0]   csum_ctl,
  input  logic [15:0]   ip_id,
  input  logic [15:0]   raw_csum,
  input  logic [63:0]   buf_addr,
  output logic          wb_valid,
  output logic          wb_type_err,
  output logic [127:0]  wb_word
);

  localparam int SEL_W = (NUM_FMT > 1) ? $clog2(NUM_FMT) : 1;
  localparam logic [LEN_W-1:0] CRC_ADD = LEN_W'(CRC_BYTES);

  rx_result_t       res;
  logic [LEN_W-1:0] len_rep;
  logic [WB_W-1:0]  fmt_word [NUM_FMT];
  logic             type_ok;
  logic             valid_d;
  logic             err_d;
  logic [WB_W-1:0]  word_d;

  rxwb_classify #(
    .IP_EN_BIT (IP_EN_BIT),
    .L4_EN_BIT (L4_EN_BIT)
  ) u_classify (
    .is_ipv4     (is_ipv4),
    .is_tcp      (is_tcp),
    .is_udp      (is_udp),
    .ip_csum_bad (ip_csum_bad),
    .l4_csum_bad (l4_csum_bad),
    .csum_ctl    (csum_ctl),
    .ip_id       (ip_id),
    .raw_csum    (raw_csum),
    .res         (res)
  );

  always_comb begin
    len_rep = crc_strip_en ? pkt_len : (pkt_len + CRC_ADD);
  end

  generate
    for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
      rxwb_pack #(
        .EXTENDED (g == 1)
      ) u_pack (
        .res       (res),
        .len_rep   (len_rep),
        .buf_addr  (buf_addr),
        .hash_slot (csum_ctl[HASH_SEL_BIT]),
        .word      (fmt_word[g])
      );
    end
  endgenerate

  // next-state
  always_comb begin
    type_ok = (32'(desc_type) < NUM_FMT);
    valid_d = in_valid & type_ok;
    err_d   = in_valid & ~type_ok;
    word_d  = fmt_word[desc_type[SEL_W-1:0]];
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid    <= 1'b0;
      wb_type_err <= 1'b0;
    end else begin
      wb_valid    <= valid_d;
      wb_type_err <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_word <= '0;
    end else if (valid_d) begin
      wb_word <= word_d;
    end
  end

endmodule

// File: rtl/rx_wb_formatter_chk.sv
module rx_wb_formatter_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [2:0]   desc_type,
  input logic         crc_strip_en,
  input logic [15:0]  pkt_len,
  input logic         wb_valid,
  input logic         wb_type_err,
  input logic [127:0] wb_word
);

  assert_bad_type_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && desc_type > 3'd1) |=> (wb_type_err && !wb_valid));

  assert_good_type_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && desc_type <= 3'd1) |=> (wb_valid && !wb_type_err));

  assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!wb_valid && !wb_type_err));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && desc_type <= 3'd1) |=> $stable(wb_word));

  assert_len_strip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && desc_type == 3'd0 && crc_strip_en) |=> (wb_word[79:64] == $past(pkt_len)));

  assert_done_leg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && desc_type == 3'd0) |=> (wb_word[97:96] == 2'b11));

  assert_done_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && desc_type == 3'd1) |=> (wb_word[65:64] == 2'b11));

  assert_vlan_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_word[127:112] == 16'h0000));

endmodule

bind rx_wb_formatter rx_wb_formatter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .desc_type    (desc_type),
  .crc_strip_en (crc_strip_en),
  .pkt_len      (pkt_len),
  .wb_valid     (wb_valid),
  .wb_type_err  (wb_type_err),
  .wb_word      (wb_word)
);

// File: tb/rx_wb_formatter_tb_top.sv
module rx_wb_formatter_tb_top;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [2:0]   desc_type;
  logic         crc_strip_en;
  logic [15:0]  pkt_len;
  logic         is_ipv4, is_tcp, is_udp;
  logic         ip_csum_bad, l4_csum_bad;
  logic [15:0]  csum_ctl, ip_id, raw_csum;
  logic [63:0]  buf_addr;
  logic         wb_valid, wb_type_err;
  logic [127:0] wb_word;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  rx_wb_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .desc_type(desc_type),
    .crc_strip_en(crc_strip_en), .pkt_len(pkt_len), .is_ipv4(is_ipv4),
    .is_tcp(is_tcp), .is_udp(is_udp), .ip_csum_bad(ip_csum_bad),
    .l4_csum_bad(l4_csum_bad), .csum_ctl(csum_ctl), .ip_id(ip_id),
    .raw_csum(raw_csum), .buf_addr(buf_addr), .wb_valid(wb_valid),
    .wb_type_err(wb_type_err), .wb_word(wb_word)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<200000 cycles", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] prev;
    rst_n = 1'b0; in_valid = 1'b0; desc_type = '0; crc_strip_en = 1'b0;
    pkt_len = '0; is_ipv4 = 0; is_tcp = 0; is_udp = 0; ip_csum_bad = 0;
    l4_csum_bad = 0; csum_ctl = '0; ip_id = '0; raw_csum = '0; buf_addr = '0;
    repeat (3) @(negedge clk);
    chk("R2 reset valid", 64'(wb_valid), 64'd0);
    chk("R2 reset err", 64'(wb_type_err), 64'd0);
    chk("R2 reset word lo", wb_word[63:0], 64'd0);
    chk("R2 reset word hi", wb_word[127:64], 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    prev = wb_word;

    for (int i = 0; i < 4096; i++) begin
      int dt, fl, bad, s, ipc, tc, uc, e_len, e_stat, e_errl, e_errx, e_pc;
      int e_cs, e_id;
      bit strip, rss;
      logic [63:0] e_slot;
      dt    = i % 8;
      strip = bit'((i / 8) % 2);
      fl    = (i / 16) % 32;
      bad   = (i / 512) % 4;
      rss   = bit'((i / 2048) % 2);

      desc_type    = 3'(dt);
      crc_strip_en = strip;
      pkt_len      = (i == 0) ? 16'hFFFE : 16'((i * 379 + 64) % 65536);
      is_ipv4      = fl[0];
      is_tcp       = fl[1];
      is_udp       = fl[2];
      ip_csum_bad  = bad[0];
      l4_csum_bad  = bad[1];
      s            = (i * 40503 + 12345) % 65536;
      csum_ctl     = 16'(s);
      csum_ctl[8]  = fl[3];
      csum_ctl[9]  = fl[4];
      csum_ctl[13] = rss;
      ip_id        = 16'(i * 13 + 5);
      raw_csum     = ~16'(i * 7);
      buf_addr     = {32'(i), ~32'(i * 3)};
      in_valid     = 1'b1;

      ipc = (fl[0] && fl[3]) ? 1 : 0;
      tc  = (fl[0] && fl[1] && fl[4]) ? 1 : 0;
      uc  = (fl[0] && fl[2] && fl[4]) ? 1 : 0;
      e_len  = (int'(pkt_len) + (strip ? 0 : 4)) % 65536;
      e_stat = 3 + 64 * ipc + 32 * tc + 16 * uc;
      e_errl = ((ipc == 1 && bad[0]) ? 64 : 0) + (((tc + uc) > 0 && bad[1]) ? 32 : 0);
      e_errx = ((ipc == 1 && bad[0]) ? 2048 : 0) + (((tc + uc) > 0 && bad[1]) ? 1024 : 0);
      e_pc   = (fl[0] ? 1 : 0) + 16 * tc + 32 * uc;
      e_cs   = ((ipc + tc + uc) > 0) ? int'(raw_csum) : 0;
      e_id   = fl[0] ? int'(ip_id) : 0;
      e_slot = rss ? 64'd0 : (64'(e_cs) * 65536 + 64'(e_id));

      @(posedge clk);
      #1 in_valid = 1'b0;
      @(negedge clk);

      if (dt > 1) begin
        chk("R1 err flag", 64'(wb_type_err), 64'd1);
        chk("R1 no valid", 64'(wb_valid), 64'd0);
        chk("R1 word held lo", wb_word[63:0], prev[63:0]);
        chk("R1 word held hi", wb_word[127:64], prev[127:64]);
      end else begin
        chk("R2 valid", 64'(wb_valid), 64'd1);
        chk("R1 no err", 64'(wb_type_err), 64'd0);
        chk("R10 vlan", 64'(wb_word[127:112]), 64'd0);
        if (dt == 0) begin
          chk("R9 address", wb_word[63:0], buf_addr);
          chk("R3 length leg", 64'(wb_word[79:64]), 64'(e_len));
          chk("R9 checksum", 64'(wb_word[95:80]), 64'(e_cs));
          chk("R4 done/eop leg", 64'(wb_word[97:96]), 64'd3);
          chk("R5 ip leg", {62'd0, wb_word[102], wb_word[110]},
              {62'd0, e_stat[6], e_errl[6]});
          chk("R6 l4 leg", {61'd0, wb_word[101:100], wb_word[109]},
              {61'd0, e_stat[5:4], e_errl[5]});
          chk("R10 other leg", {54'd0, wb_word[99:98], wb_word[103], wb_word[108:104], wb_word[111]},
              {54'd0, e_stat[3:2], e_stat[7], e_errl[4:0], e_errl[7]});
        end else begin
          chk("R7 class", 64'(wb_word[15:4]), 64'(e_pc));
          chk("R8 slot", 64'(wb_word[63:32]), e_slot);
          chk("R3 length ext", 64'(wb_word[111:96]), 64'(e_len));
          chk("R4 done/eop ext", 64'(wb_word[65:64]), 64'd3);
          chk("R5 ip ext", {62'd0, wb_word[70], wb_word[95]},
              {62'd0, e_stat[6], e_errx[11]});
          chk("R6 l4 ext", {61'd0, wb_word[69:68], wb_word[94]},
              {61'd0, e_stat[5:4], e_errx[10]});
          chk("R8 status/errors", {32'd0, wb_word[95:64]},
              {32'd0, 12'(e_errx), 20'(e_stat)});
          chk("R10 zero ext", {28'd0, wb_word[3:0], wb_word[31:16], wb_word[83:71], 3'b0},
              64'd0);
        end
      end
      prev = wb_word;

      @(negedge clk);
      chk("R2 idle valid", 64'(wb_valid), 64'd0);
      chk("R2 idle err", 64'(wb_type_err), 64'd0);
      chk("R2 idle hold", wb_word[127:64] ^ prev[127:64], 64'd0);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule